// File: doc/BRIEF.md
# Pulse Accumulator Counter

An 8-bit counter fed by a single external pulse pin, with two operating modes. In event mode it counts transitions of the pin in one chosen direction. In gated mode it counts ticks of an internal timebase, but only while the pin sits at a chosen level. Either way, it measures activity on the pin: how many pulses arrived, or how long the pin stayed asserted in timebase units.

The pin is resynchronised before any decision is taken. A single polarity input selects the active edge in event mode and the active level in gated mode. Two sticky flags report activity. One is set when the count wraps past its top value. The other is set when an input event is recognised. Each flag has its own clear strobe. Software can preset the count through a parallel load port.

Top module: `pulse_acc_top`

## Requirements
- R1: While rst_ni is low and after its release, count_o reads 0, ovf_flag_o is 0 and in_flag_o is 0.
- R2: With mode_i=0 (event) and en_i=1, count_o increments by exactly one for each rising pin_i transition when pol_i=1, and for each falling transition when pol_i=0. The opposite transition does not change the count.
- R3: pin_i passes through two synchroniser flops. A counted transition shows on count_o at the third rising clock edge after pin_i changes.
- R4: With mode_i=1 (gated) and en_i=1, count_o increments once per timebase tick while the synchronised pin equals pol_i. The tick occurs every 64 clocks and runs freely from reset, so holding the pin active for exactly 640 clocks adds exactly 10.
- R5: With en_i=0, the count does not increment and in_flag_o is not set. This holds in both modes.
- R6: An increment from 0xFF yields 0x00 and sets ovf_flag_o.
- R7: in_flag_o is set by each counted edge in event mode. In gated mode it is set when the pin leaves the active level, and stays clear while the pin is held active.
- R8: load_i=1 writes load_val_i into the count on the next clock. It has priority over any increment in the same cycle.
- R9: Each flag stays set until its clear strobe (ovf_clr_i, in_clr_i) is high at a clock edge. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Counting enable |
| mode_i | input | 1 | 0 = event counting, 1 = gated time |
| pol_i | input | 1 | 1 = rising edge / high level active, 0 = falling / low |
| pin_i | input | 1 | Asynchronous pulse input |
| load_i | input | 1 | Load strobe |
| load_val_i | input | 8 | Value written on load |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| in_clr_i | input | 1 | Clears the input flag |
| count_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Sticky rollover flag |
| in_flag_o | output | 1 | Sticky input-event flag |

## Verification
An edge detector with the wrong polarity makes the count move on the wrong half of a pulse. This shows three clocks after the pin changes. A wrong timebase phase or divide ratio shows as a count that is off after a fixed 640-clock gated window. A dropped load priority appears as drift while load is held during pulses. A rollover fault shows as ovf_flag_o in the wrong state one clock after the 0xFF increment. A mis-wired end-of-level flag appears as in_flag_o set while the pin is still active.

// File: rtl/pacc_pkg.sv
`timescale 1ns/1ps
package pacc_pkg;
  typedef enum logic {
    MODE_EVENT = 1'b0,
    MODE_GATED = 1'b1
  } pacc_mode_e;
endpackage

// File: rtl/pacc_sync_edge.sv
`timescale 1ns/1ps
module pacc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic act_o,
  output logic act_rise_o,
  output logic act_fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              act_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  // polarity applied to both samples: a pol change alone never makes an edge
  assign act_o      = sync_q[STAGES-1] ~^ pol_i;
  assign act_prev   = prev_q ~^ pol_i;
  assign act_rise_o = act_o & ~act_prev;
  assign act_fall_o = ~act_o & act_prev;

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_rise_o || act_fall_o) |-> (sync_q[STAGES-1] != prev_q)) else $error("edge"); // R2
endmodule

// File: rtl/pacc_tick_gen.sv
`timescale 1ns/1ps
module pacc_tick_gen #(
  parameter int TICK_DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + DW'(1);
  end

  assign tick_o = (div_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o) else $error("tick"); // R4
endmodule

// File: rtl/pacc_counter.sv
`timescale 1ns/1ps
module pacc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~load_i & (&cnt_q);

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)) else $error("load"); // R8
  AST_INC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1)) else $error("inc"); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(cnt_q)) else $error("hold"); // R5
endmodule

// File: rtl/pulse_acc_top.sv
`timescale 1ns/1ps
module pulse_acc_top
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TICK_DIV    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic             pin_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             ovf_clr_i,
  input  logic             in_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             in_flag_o
);
  pacc_mode_e mode;
  logic act, act_rise, act_fall, tick, inc, wrap, in_set;
  logic ovf_q, in_q;

  assign mode = pacc_mode_e'(mode_i);

  pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i, .pol_i,
    .act_o(act), .act_rise_o(act_rise), .act_fall_o(act_fall)
  );

  pacc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  always_comb begin
    if (mode == MODE_GATED) begin
      inc    = en_i & act & tick;
      in_set = en_i & act_fall;
    end else begin
      inc    = en_i & act_rise;
      in_set = en_i & act_rise;
    end
  end

  pacc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i, .load_val_i,
    .inc_i(inc), .cnt_o(count_o), .wrap_o(wrap)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      in_q  <= 1'b0;
    end else begin
      ovf_q <= wrap   | (ovf_q & ~ovf_clr_i);
      in_q  <= in_set | (in_q  & ~in_clr_i);
    end
  end

  assign ovf_flag_o = ovf_q;
  assign in_flag_o  = in_q;

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf_flag_o && count_o == '0) else $error("ovf"); // R6
  AST_IN_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_set && in_clr_i) |=> in_flag_o) else $error("inset"); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o) else $error("ovfs"); // R9
  AST_EN_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(count_o)) else $error("en"); // R5
endmodule

// File: tb/sim_pulse_acc_top.sv
`timescale 1ns/1ps
module sim_pulse_acc_top;
  logic clk = 0, rst_n = 0;
  logic en = 0, mode = 0, pol = 1, pin = 0, load = 0, oclr = 0, iclr = 0;
  logic [7:0] lval = '0;
  logic [7:0] cnt;
  logic ovf, inf;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pulse_acc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .pol_i(pol),
    .pin_i(pin), .load_i(load), .load_val_i(lval), .ovf_clr_i(oclr),
    .in_clr_i(iclr), .count_o(cnt), .ovf_flag_o(ovf), .in_flag_o(inf)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_flags();
    oclr = 1; iclr = 1; idle(1); oclr = 0; iclr = 0;
  endtask

  task automatic do_load(input logic [7:0] v);
    lval = v; load = 1; idle(1); load = 0;
  endtask

  task automatic pulse(input logic lvl);
    pin = lvl; idle(5); pin = ~lvl; idle(5);
  endtask

  task automatic t_reset();
    chk("R1 count", cnt, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 inflag", inf, 0);
  endtask

  task automatic t_event_rise();
    en = 1; mode = 0; pol = 1; pin = 0; idle(4);
    do_load(8'd0); clr_flags();
    for (int i = 0; i < 5; i++) pulse(1'b1);
    chk("R2 rising count", cnt, 5);
    chk("R7 event flag", inf, 1);
  endtask

  task automatic t_event_fall();
    en = 1; mode = 0; pol = 0; pin = 0; idle(4);
    do_load(8'd20); clr_flags();
    pin = 1; idle(6);
    chk("R2 rise ignored pol0", cnt, 20);
    chk("R7 no flag on ignored edge", inf, 0);
    pin = 0; idle(6);
    chk("R2 falling counted", cnt, 21);
  endtask

  task automatic t_sync_latency();
    en = 1; mode = 0; pol = 1; pin = 0; idle(4);
    do_load(8'd40);
    @(negedge clk); pin = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R3 not yet after 2 edges", cnt, 40);
    @(posedge clk); #1;
    chk("R3 counted at third edge", cnt, 41);
    idle(3); pin = 0; idle(4);
  endtask

  task automatic t_gated(input logic p);
    en = 1; mode = 1; pol = p; pin = ~p; idle(6);
    do_load(8'd3); clr_flags();
    @(negedge clk); pin = p;
    idle(640);
    pin = ~p;
    chk("R7 gated flag clear while active", inf, 0);
    idle(6);
    chk("R4 gated 640 clocks", cnt, 13);
    chk("R7 gated end flag", inf, 1);
  endtask

  task automatic t_disabled();
    en = 0; mode = 0; pol = 1; pin = 0; idle(4);
    do_load(8'd50); clr_flags();
    for (int i = 0; i < 3; i++) pulse(1'b1);
    chk("R5 event disabled", cnt, 50);
    chk("R5 flag disabled", inf, 0);
    mode = 1; pin = 1; idle(200); pin = 0; idle(6);
    chk("R5 gated disabled", cnt, 50);
  endtask

  task automatic t_rollover();
    en = 1; mode = 0; pol = 1; pin = 0; idle(4);
    do_load(8'hFE); clr_flags();
    pulse(1'b1);
    chk("R6 at FF", cnt, 255);
    chk("R6 no ovf yet", ovf, 0);
    pulse(1'b1);
    chk("R6 wrap to 0", cnt, 0);
    chk("R6 ovf set", ovf, 1);
    idle(20);
    chk("R9 ovf sticky", ovf, 1);
    oclr = 1; idle(1); oclr = 0;
    chk("R9 ovf cleared", ovf, 0);
  endtask

  task automatic t_load_prio();
    en = 1; mode = 0; pol = 1; pin = 0; idle(4);
    lval = 8'd77; load = 1;
    for (int i = 0; i < 3; i++) pulse(1'b1);
    load = 0; idle(1);
    chk("R8 load holds over increments", cnt, 77);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1; idle(2);
    t_reset();
    t_event_rise();
    t_event_fall();
    t_sync_latency();
    t_gated(1'b1);
    t_gated(1'b0);
    t_disabled();
    t_rollover();
    t_load_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule